// File: doc/BRIEF.md
# Exponential Soft-Mute Gain Ramp

This block moves a left and a right gain code toward their target codes, one code step for each pulse of a step strobe. The strobe runs at twice the output sample rate. A gain code packs a 5-bit exponent index above an 8-bit mantissa. Above index zero the mantissa only takes its upper half, from 0x80 to 0xFF. At index zero the mantissa covers the whole range, so the code runs linearly down to silence. Walking the code one step at a time therefore gives a fade that is exponential in pieces, with a linear tail at the bottom.

A mute request replaces both targets with zero, so the gains fade out. When mute is released, the gains ramp back up to whatever target the host is still presenting. A share mode makes both channels follow the left target. Each channel has a done flag that says whether its gain has reached its effective target. The block does not multiply samples and does not convert from decibels.

Top module: `gain_ramp`

## Requirements
- R1: A gain code is {index[12:8], mantissa[7:0]}. The only legal outputs are index 0 with any mantissa, or index 1..20 with mantissa 0x80..0xFF. After a synchronous reset both gains are 0x0000 and both done flags are 1.
- R2: A gain changes only on a clock edge where step_en is 1. It then moves by exactly one legal code toward its registered target and never passes that target. With step_en at 0 the gain holds.
- R3: Stepping down from {i,0x80} with i>0 gives {i-1,0xFF}. At index 0 each step down lowers the mantissa by 1, down to 0x0000.
- R4: Stepping up from {i,0xFF} gives {i+1,0x80}, including {0,0xFF} to {1,0x80}. Any other step up raises the mantissa by 1.
- R5: The target inputs are registered with one cycle of latency. A step on an edge moves toward the target that was registered before that edge.
- R6: A target above {20,0xFF} (0x14FF) is clamped to 0x14FF.
- R7: A target with index above 0 and mantissa below 0x80 is raised to {index,0x80}.
- R8: While mute_req is 1 the effective target of both channels is 0x0000. After release the gains ramp back to the presented targets.
- R9: When share_lr is 1 the right channel uses tgt_l (after R6/R7) as its target, and tgt_r has no effect.
- R10: A done flag is 1 exactly when its gain equals its registered effective target. It drops in the same cycle that a different target is registered.
- R11: A full fade from 0x14FF to 0x0000 takes 2815 strobes. With a strobe on every cycle, done rises 2816 cycles after mute is first presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Ramp step strobe (2x output sample rate) |
| mute_req | input | 1 | Force both targets to zero |
| share_lr | input | 1 | Right channel follows the left target |
| tgt_l | input | 13 | Left target code {index, mantissa} |
| tgt_r | input | 13 | Right target code {index, mantissa} |
| gain_l | output | 13 | Current left gain code |
| gain_r | output | 13 | Current right gain code |
| done_l | output | 1 | Left gain equals its target |
| done_r | output | 1 | Right gain equals its target |

## Verification
A step strobe and a target update can land on the same edge. The step must then head toward the previously registered target, while the done flag already compares against the new one. The bench provokes this by changing the target, or toggling mute, on cycles where the strobe is high, including a run where the target alternates on every strobe. A reference model works in linear step positions rather than in packed codes and predicts both gains and both done flags for every cycle, and each cycle's outputs are compared against that prediction.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;
  typedef enum logic [1:0] {DIR_HOLD = 2'd0, DIR_DOWN = 2'd1, DIR_UP = 2'd2} ramp_dir_e;
endpackage

// File: rtl/gain_ramp_target.sv
module gain_ramp_target #(
  parameter int IDX_W   = 5,
  parameter int MAN_W   = 8,
  parameter int IDX_MAX = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mute_in,
  input  logic [IDX_W+MAN_W-1:0] code_in,
  output logic [IDX_W+MAN_W-1:0] tgt_d,
  output logic [IDX_W+MAN_W-1:0] tgt_q
);
  localparam int CW = IDX_W + MAN_W;
  localparam logic [CW-1:0] MAX_CODE = CW'((IDX_MAX << MAN_W) + (2 ** MAN_W - 1));
  localparam logic [MAN_W-1:0] HALF = {1'b1, {(MAN_W-1){1'b0}}};

  logic [CW-1:0] norm;

  // Clamp to the top code, then lift mantissas that are illegal above index 0
  always_comb begin
    norm = code_in;
    if (code_in > MAX_CODE)
      norm = MAX_CODE;
    else if (code_in[CW-1:MAN_W] != '0 && !code_in[MAN_W-1])
      norm = {code_in[CW-1:MAN_W], HALF};
    tgt_d = mute_in ? '0 : norm;
  end

  always_ff @(posedge clk) begin
    if (rst) tgt_q <= '0;
    else     tgt_q <= tgt_d;
  end

  p_mute_zero_r8: assert property (@(posedge clk) disable iff (rst)
    mute_in |=> (tgt_q == '0));
  p_clamp_max_r6: assert property (@(posedge clk) disable iff (rst)
    tgt_q <= MAX_CODE);
  p_legal_target_r7: assert property (@(posedge clk) disable iff (rst)
    (tgt_q[CW-1:MAN_W] != '0) |-> tgt_q[MAN_W-1]);
endmodule

// File: rtl/gain_ramp_chan.sv
module gain_ramp_chan
  import gain_ramp_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int MAN_W   = 8,
  parameter int IDX_MAX = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step_en,
  input  logic [IDX_W+MAN_W-1:0] tgt_d,
  input  logic [IDX_W+MAN_W-1:0] tgt_q,
  output logic [IDX_W+MAN_W-1:0] cur_q,
  output logic                   done_q
);
  localparam int CW = IDX_W + MAN_W;
  localparam logic [MAN_W-1:0] HALF = {1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [MAN_W-1:0] FULL = {MAN_W{1'b1}};

  logic [IDX_W-1:0] idx;
  logic [MAN_W-1:0] man;
  logic [CW-1:0]    cur_nxt;
  ramp_dir_e        dir;

  assign idx = cur_q[CW-1:MAN_W];
  assign man = cur_q[MAN_W-1:0];

  always_comb begin
    if (cur_q > tgt_q)      dir = DIR_DOWN;
    else if (cur_q < tgt_q) dir = DIR_UP;
    else                    dir = DIR_HOLD;
  end

  always_comb begin
    cur_nxt = cur_q;
    if (step_en) begin
      unique case (dir)
        DIR_DOWN: cur_nxt = (idx != '0 && man == HALF) ? {idx - 1'b1, FULL} : cur_q - 1'b1;
        DIR_UP:   cur_nxt = (man == FULL) ? {idx + 1'b1, HALF} : cur_q + 1'b1;
        default:  cur_nxt = cur_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      done_q <= 1'b1;
    end else begin
      cur_q  <= cur_nxt;
      done_q <= (cur_nxt == tgt_d);
    end
  end

  p_hold_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(cur_q));
  p_no_overshoot_r2: assert property (@(posedge clk) disable iff (rst)
    (cur_q < tgt_q) |=> (cur_q <= $past(tgt_q)));
  p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
    (idx <= IDX_MAX[IDX_W-1:0]) && ((idx == '0) || man[MAN_W-1]));
  p_wrap_down_r3: assert property (@(posedge clk) disable iff (rst)
    (step_en && cur_q > tgt_q && idx != '0 && man == HALF)
      |=> (cur_q == {$past(idx) - 1'b1, FULL}));
  p_wrap_up_r4: assert property (@(posedge clk) disable iff (rst)
    (step_en && cur_q < tgt_q && man == FULL)
      |=> (cur_q == {$past(idx) + 1'b1, HALF}));
  p_done_match_r10: assert property (@(posedge clk) disable iff (rst)
    done_q == (cur_q == tgt_q));
endmodule

// File: rtl/gain_ramp.sv
module gain_ramp #(
  parameter int IDX_W   = 5,
  parameter int MAN_W   = 8,
  parameter int IDX_MAX = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step_en,
  input  logic                   mute_req,
  input  logic                   share_lr,
  input  logic [IDX_W+MAN_W-1:0] tgt_l,
  input  logic [IDX_W+MAN_W-1:0] tgt_r,
  output logic [IDX_W+MAN_W-1:0] gain_l,
  output logic [IDX_W+MAN_W-1:0] gain_r,
  output logic                   done_l,
  output logic                   done_r
);
  localparam int CW  = IDX_W + MAN_W;
  localparam int NCH = 2;

  logic [NCH-1:0][CW-1:0] req;
  logic [NCH-1:0][CW-1:0] t_d;
  logic [NCH-1:0][CW-1:0] t_q;
  logic [NCH-1:0][CW-1:0] cur;
  logic [NCH-1:0]         done;

  assign req[0] = tgt_l;
  assign req[1] = share_lr ? tgt_l : tgt_r;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gain_ramp_target #(.IDX_W(IDX_W), .MAN_W(MAN_W), .IDX_MAX(IDX_MAX)) u_tgt (
      .clk(clk), .rst(rst), .mute_in(mute_req), .code_in(req[c]),
      .tgt_d(t_d[c]), .tgt_q(t_q[c])
    );
    gain_ramp_chan #(.IDX_W(IDX_W), .MAN_W(MAN_W), .IDX_MAX(IDX_MAX)) u_chan (
      .clk(clk), .rst(rst), .step_en(step_en), .tgt_d(t_d[c]), .tgt_q(t_q[c]),
      .cur_q(cur[c]), .done_q(done[c])
    );
  end

  assign gain_l = cur[0];
  assign gain_r = cur[1];
  assign done_l = done[0];
  assign done_r = done[1];

  p_shared_target_r9: assert property (@(posedge clk) disable iff (rst)
    share_lr |=> (t_q[1] == t_q[0]));
endmodule

// File: tb/gain_ramp_tb.sv
`timescale 1ns/1ps
module gain_ramp_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, step_en = 1'b0, mute_req = 1'b0, share_lr = 1'b0;
  logic [12:0] tgt_l = '0, tgt_r = '0;
  logic [12:0] gain_l, gain_r;
  logic        done_l, done_r;

  gain_ramp u_dut (
    .clk(clk), .rst(rst), .step_en(step_en), .mute_req(mute_req), .share_lr(share_lr),
    .tgt_l(tgt_l), .tgt_r(tgt_r), .gain_l(gain_l), .gain_r(gain_r),
    .done_l(done_l), .done_r(done_r)
  );

  typedef struct {
    logic [12:0] gl;
    logic [12:0] gr;
    logic        dl;
    logic        dr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, bad = 0, wd = 0;
  int m_cur[2], m_tq[2];

  function automatic int pos_of(logic [12:0] c);
    return int'(c[12:8]) * 128 + int'(c[7:0]);
  endfunction
  function automatic logic [12:0] code_of(int p);
    if (p < 256) return 13'(p);
    return {5'(p / 128 - 1), 8'(p % 128 + 128)};
  endfunction
  function automatic int norm_pos(logic [12:0] c);
    if (c > 13'h14FF) return 2815;
    if (c[12:8] != 0 && !c[7]) return pos_of({c[12:8], 8'h80});
    return pos_of(c);
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs after the next edge
  task automatic cyc(bit st, bit mu, bit sh, logic [12:0] l, logic [12:0] r, string tag);
    exp_t e;
    @(negedge clk);
    step_en = st; mute_req = mu; share_lr = sh; tgt_l = l; tgt_r = r;
    for (int c = 0; c < 2; c++) begin
      int nt = mu ? 0 : norm_pos((c == 0 || sh) ? l : r);
      int nc = m_cur[c];
      if (st) begin
        if (nc > m_tq[c]) nc--;
        else if (nc < m_tq[c]) nc++;
      end
      m_cur[c] = nc;
      m_tq[c]  = nt;
    end
    e.gl = code_of(m_cur[0]); e.gr = code_of(m_cur[1]);
    e.dl = (m_cur[0] == m_tq[0]); e.dr = (m_cur[1] == m_tq[1]);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares one expected item per edge, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (gain_l !== e.gl || gain_r !== e.gr || done_l !== e.dl || done_r !== e.dr) begin
        bad++;
        $display("FAIL %s: got gl=%h gr=%h dl=%b dr=%b expected gl=%h gr=%h dl=%b dr=%b",
                 e.tag, gain_l, gain_r, done_l, done_r, e.gl, e.gr, e.dl, e.dr);
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      bad++;
      $display("FAIL watchdog R2: cycles=%0d expected below 100000", wd);
      summary();
    end
  end

  initial begin
    int n;
    m_cur = '{0, 0}; m_tq = '{0, 0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (gain_l !== 0 || gain_r !== 0 || done_l !== 1 || done_r !== 1) begin
      bad++;
      $display("FAIL R1 reset: got gl=%h gr=%h dl=%b dr=%b expected 0000 0000 1 1",
               gain_l, gain_r, done_l, done_r);
    end
    rst = 1'b0;

    // R5/R10: new target registers, done drops, gain holds without strobe (R2)
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 13'h14FF, 13'h03C8, "R10 target change no strobe");
    // R4: ramp up through every upward wrap
    for (int i = 0; i < 2820; i++) cyc(1, 0, 0, 13'h14FF, 13'h03C8, "R4 ramp up");
    // R11/R8: full fade on mute, counted
    n = 0;
    for (int i = 0; i < 2900; i++) begin
      cyc(1, 1, 0, 13'h14FF, 13'h03C8, "R8 mute fade");
      n++;
      @(posedge clk); #1;
      if (done_l) break;
    end
    checks++;
    if (n != 2816) begin
      bad++;
      $display("FAIL R11 full fade: got cycles=%0d expected 2816", n);
    end
    // R8 release with R2 sparse strobes
    for (int i = 0; i < 1500; i++) cyc(i % 3 == 0, 0, 0, 13'h0290, 13'h03C8, "R8 release sparse R2");
    // R6 clamp of oversized targets
    for (int i = 0; i < 2500; i++) cyc(1, 0, 0, 13'h1FFF, 13'h1500, "R6 clamp");
    // R3 down through wraps into linear tail; R7 illegal mantissa on right
    for (int i = 0; i < 2850; i++) cyc(1, 0, 0, 13'h0005, 13'h0510, "R3 R7 ramp down");
    // R9 shared target
    for (int i = 0; i < 1100; i++) cyc(1, 0, 1, 13'h07C0, 13'h0000, "R9 shared");
    // R5 coincidence: target and mute change on strobe cycles
    for (int i = 0; i < 24; i++) cyc(1, i % 5 == 4, 0, (i % 2) ? 13'h0180 : 13'h0010, 13'h07C0, "R5 coincident step");
    for (int i = 0; i < 400; i++) cyc(1, 0, 0, 13'h0180, 13'h07C0, "R5 settle");
    @(posedge clk); #2;
    summary();
  end
endmodule